// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a small word-wide register bus. Each counter has its own run bit, auto-reload bit, clock-source select and 3-bit log2 prescaler. A counter is clocked either by single-cycle pulses on a shared reference-tick input, or by the system clock divided by a power of two. Software can load the current value directly to arm a one-shot delay. It can also program a reload value and let the counter repeat with a fixed period.

When a running counter reaches zero on a tick, it raises a sticky event flag, and any set flag drives the interrupt output. After that the counter either reloads from its reload register and keeps going, or it parks at zero and its run bit clears. Software clears a flag by writing a word that holds 0 in that flag's bit position. Bits written as 1 leave the flags alone.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x10/0x14 (timer 0 reload/value) and 0x18/0x1C (timer 1 reload/value). A read of any other offset returns 0, and a write to one changes nothing.
- R3: Control bits: timer 0 uses bit 0 (run), bit 1 (auto-reload), bit 11 (reference-tick select) and bits 21:19 (log2 divide). Timer 1 uses bit 2 (run), bit 3 (auto-reload), bit 12 (reference-tick select) and bits 24:22 (log2 divide). The register reads back 0x01F8180F after 0xFFFFFFFF is written, because all other bits read 0.
- R4: A write to a value register loads that counter on the next edge. A running counter decreases by one on each of its ticks.
- R5: With its select bit set, a timer ticks once for each cycle that `ref_tick` is high. With the bit clear, a timer whose divide field holds n ticks once every 2^n system cycles. Its first tick falls 2^n cycles after the control write, because every control write restarts both prescalers.
- R6: A running counter that is 0 on a tick expires. On the next edge the timer's flag sets (status bit 0 for timer 0, bit 8 for timer 1), and `irq` is high while either flag is set.
- R7: On expiry with auto-reload set, the counter takes its reload value and keeps running. With a reload value of 0xFFFFFFFF it behaves as a free-running down-counter.
- R8: On expiry with auto-reload clear, the counter stays at 0 and the timer's run bit clears itself.
- R9: While a timer's run bit is clear, its counter holds its value whatever ticks arrive.
- R10: A status write clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. When an expiry and a clear of the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current address and data |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 1 | Reference tick pulse, one tick per high cycle |
| irq | output | 1 | High while any event flag is set |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are steady for a whole cycle around each write strobe, and that `ref_tick` is a clean synchronous level counted once per high cycle. They also assume that a run bit is only cleared by software or by a one-shot expiry. The bench drives every bus transaction and every reference pulse one nanosecond after a rising edge and holds it for exactly one cycle, so each reference pulse is exactly one tick. In the prescaled cases it counts idle cycles from the control write, so the expected counter value follows from the 2^n spacing alone.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;
   localparam int NUM_TMR = 2;
   localparam int PRE_W   = 3;
   localparam int OFF_CTRL = 'h00;
   localparam int OFF_STAT = 'h04;

   function automatic int off_reload(input int i);
      return 'h10 + 8 * i;
   endfunction
   function automatic int off_value(input int i);
      return 'h14 + 8 * i;
   endfunction
   function automatic int bit_run(input int i);
      return 2 * i;
   endfunction
   function automatic int bit_autorl(input int i);
      return 2 * i + 1;
   endfunction
   function automatic int bit_refsel(input int i);
      return 11 + i;
   endfunction
   function automatic int bit_pre_lo(input int i);
      return 19 + PRE_W * i;
   endfunction
   function automatic int bit_flag(input int i);
      return 8 * i;
   endfunction

   function automatic logic [31:0] ctrl_mask();
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < NUM_TMR; i++) begin
         m[bit_run(i)]    = 1'b1;
         m[bit_autorl(i)] = 1'b1;
         m[bit_refsel(i)] = 1'b1;
         for (int b = 0; b < PRE_W; b++) m[bit_pre_lo(i) + b] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/dtmr_tick.sv
`timescale 1ns/1ps
module dtmr_tick #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             sel_ref,
   input  logic             ref_tick,
   input  logic [PRE_W-1:0] div_log2,
   output logic             tick
);
   localparam int CW = (1 << PRE_W) - 1;

   if (PRE_W < 1 || PRE_W > 5) begin : g_bad_pre
      $error("dtmr_tick: PRE_W out of range");
   end

   logic [CW-1:0] pre_cnt;
   logic [CW-1:0] lo_mask;
   logic          fab_tick;

   // divide-by-2^n: all low n bits of the free counter set
   assign lo_mask  = (CW'(1) << div_log2) - CW'(1);
   assign fab_tick = &(pre_cnt | ~lo_mask);
   assign tick     = sel_ref ? ref_tick : fab_tick;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) pre_cnt <= '0;
      else                   pre_cnt <= pre_cnt + CW'(1);
   end
endmodule

// File: rtl/dtmr_counter.sv
`timescale 1ns/1ps
module dtmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             auto_rl,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] value,
   output logic             expire
);
   logic at_zero;

   assign at_zero = (value == '0);
   assign expire  = run && tick && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
      end else if (load) begin
         value <= load_val;
      end else if (run && tick) begin
         if (!at_zero)     value <= value - CNT_W'(1);
         else if (auto_rl) value <= reload_val;
      end
   end
endmodule

// File: rtl/dual_down_timer.sv
`timescale 1ns/1ps
module dual_down_timer
   import dtmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ref_tick,
   output logic              irq
);
   localparam logic [31:0] CTRL_MASK = ctrl_mask();

   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
      $error("dual_down_timer: CNT_W must be 8..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("dual_down_timer: ADDR_W too small for the map");
   end

   logic [31:0]                     ctrl_q, ctrl_d;
   logic [NUM_TMR-1:0]              flag_q, flag_d;
   logic [NUM_TMR-1:0]              tmr_exp, tmr_run, tmr_rl, tmr_tick;
   logic [NUM_TMR-1:0]              val_ld, rld_ld;
   logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_val, rld_q;
   logic                            wr_ctrl, wr_stat;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      assign val_ld[i]  = bus_wr && (bus_addr == ADDR_W'(off_value(i)));
      assign rld_ld[i]  = bus_wr && (bus_addr == ADDR_W'(off_reload(i)));
      assign tmr_run[i] = ctrl_q[bit_run(i)];
      assign tmr_rl[i]  = ctrl_q[bit_autorl(i)];

      dtmr_tick #(.PRE_W(PRE_W)) u_tick (
         .clk      (clk),
         .rst_n    (rst_n),
         .restart  (wr_ctrl),
         .sel_ref  (ctrl_q[bit_refsel(i)]),
         .ref_tick (ref_tick),
         .div_log2 (ctrl_q[bit_pre_lo(i) +: PRE_W]),
         .tick     (tmr_tick[i])
      );

      dtmr_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tmr_tick[i]),
         .run        (tmr_run[i]),
         .auto_rl    (tmr_rl[i]),
         .load       (val_ld[i]),
         .load_val   (bus_wdata[CNT_W-1:0]),
         .reload_val (rld_q[i]),
         .value      (cnt_val[i]),
         .expire     (tmr_exp[i])
      );
   end

   always_comb begin
      ctrl_d = ctrl_q;
      for (int i = 0; i < NUM_TMR; i++) begin
         if (tmr_exp[i] && !tmr_rl[i]) ctrl_d[bit_run(i)] = 1'b0;
      end
      if (wr_ctrl) ctrl_d = bus_wdata & CTRL_MASK;
   end

   // set beats write-zero clear
   always_comb begin
      for (int i = 0; i < NUM_TMR; i++) begin
         flag_d[i] = tmr_exp[i] |
                     (flag_q[i] & ~(wr_stat & ~bus_wdata[bit_flag(i)]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= '0;
         rld_q  <= '0;
      end else begin
         ctrl_q <= ctrl_d;
         flag_q <= flag_d;
         for (int i = 0; i < NUM_TMR; i++) begin
            if (rld_ld[i]) rld_q[i] <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   assign irq = |flag_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_q;
      if (bus_addr == ADDR_W'(OFF_STAT)) begin
         for (int i = 0; i < NUM_TMR; i++) bus_rdata[bit_flag(i)] = flag_q[i];
      end
      for (int i = 0; i < NUM_TMR; i++) begin
         if (bus_addr == ADDR_W'(off_reload(i))) bus_rdata = 32'(rld_q[i]);
         if (bus_addr == ADDR_W'(off_value(i)))  bus_rdata = 32'(cnt_val[i]);
      end
   end
endmodule

// File: rtl/dtmr_checker.sv
`timescale 1ns/1ps
module dtmr_checker #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8,
   parameter int NT     = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [31:0]             bus_rdata,
   input logic                    irq,
   input logic                    wr_ctrl,
   input logic                    wr_stat,
   input logic [NT-1:0]           stat_wbits,
   input logic [NT-1:0]           flag_q,
   input logic [NT-1:0]           tmr_exp,
   input logic [NT-1:0]           tmr_run,
   input logic [NT-1:0]           tmr_rl,
   input logic [NT-1:0]           val_ld,
   input logic [NT-1:0][CNT_W-1:0] cnt_val,
   input logic [NT-1:0][CNT_W-1:0] rld_q
);
   logic mapped;
   assign mapped = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)) ||
                   (bus_addr == ADDR_W'('h10)) || (bus_addr == ADDR_W'('h14)) ||
                   (bus_addr == ADDR_W'('h18)) || (bus_addr == ADDR_W'('h1C));

   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == 32'd0) else $error("unmapped read not zero");

   p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tmr_exp != '0)) else $error("irq rose without expiry");

   for (genvar i = 0; i < NT; i++) begin : g_p
      p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_exp[i] |=> flag_q[i]) else $error("flag missing after expiry");

      p_flag_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
         flag_q[i] && !(wr_stat && !stat_wbits[i]) |=> flag_q[i])
         else $error("flag lost without zero write");

      p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_exp[i] && !tmr_rl[i] && !wr_ctrl && !val_ld[i]
         |=> !tmr_run[i] && cnt_val[i] == '0) else $error("one-shot did not stop");

      p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_exp[i] && tmr_rl[i] && !val_ld[i] |=> cnt_val[i] == $past(rld_q[i]))
         else $error("periodic reload wrong");

      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !tmr_run[i] && !val_ld[i] |=> $stable(cnt_val[i]))
         else $error("stopped counter moved");
   end
endmodule

bind dual_down_timer dtmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NT(dtmr_pkg::NUM_TMR)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .irq        (irq),
   .wr_ctrl    (wr_ctrl),
   .wr_stat    (wr_stat),
   .stat_wbits ({bus_wdata[dtmr_pkg::bit_flag(1)], bus_wdata[dtmr_pkg::bit_flag(0)]}),
   .flag_q     (flag_q),
   .tmr_exp    (tmr_exp),
   .tmr_run    (tmr_run),
   .tmr_rl     (tmr_rl),
   .val_ld     (val_ld),
   .cnt_val    (cnt_val),
   .rld_q      (rld_q)
);

// File: tb/dual_down_timer_tb_top.sv
`timescale 1ns/1ps
module dual_down_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ref_tick = 1'b0;
   logic        irq;

   always #2 clk = ~clk;

   dual_down_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick), .irq(irq)
   );

   typedef struct {
      logic        is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sbq[$];
   logic  sample_en = 1'b0;
   int    n_chk = 0;
   int    n_err = 0;
   logic  done = 1'b0;

   // monitor: compares away from the active edge
   always @(negedge clk) begin
      if (sample_en && sbq.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sbq.pop_front();
         act = it.is_irq ? {31'd0, irq} : bus_rdata;
         n_chk++;
         if (act !== it.exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      sample_en = 1'b1;
      @(posedge clk); #1;
      sample_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
      sbq.push_back(it);
      sample_en = 1'b1;
      @(posedge clk); #1;
      sample_en = 1'b0;
   endtask

   task automatic pulse();
      @(posedge clk); #1;
      ref_tick = 1'b1;
      @(posedge clk); #1;
      ref_tick = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk_rd(8'h00, 32'h0, "R1 ctrl");
      chk_rd(8'h04, 32'h0, "R1 status");
      chk_rd(8'h10, 32'h0, "R1 reload0");
      chk_rd(8'h14, 32'h0, "R1 value0");
      chk_rd(8'h18, 32'h0, "R1 reload1");
      chk_rd(8'h1C, 32'h0, "R1 value1");
      chk_irq(1'b0, "R1 irq");

      // R3 control layout
      wr(8'h00, 32'hFFFF_FFFF);
      chk_rd(8'h00, 32'h01F8_180F, "R3 ctrl readback");
      wr(8'h00, 32'h0);

      // R2 unmapped offsets
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h20, 32'h1234_5678);
      chk_rd(8'h08, 32'h0, "R2 unmapped 08");
      chk_rd(8'h20, 32'h0, "R2 unmapped 20");
      chk_rd(8'h00, 32'h0, "R2 ctrl untouched");
      chk_rd(8'h10, 32'h0, "R2 reload0 untouched");

      // R4 / R5 reference-tick one-shot on timer 0
      wr(8'h14, 32'd3);
      chk_rd(8'h14, 32'd3, "R4 value load");
      wr(8'h00, 32'h0000_0801);
      repeat (10) @(posedge clk);
      chk_rd(8'h14, 32'd3, "R5 no ref pulse no count");
      pulse();
      chk_rd(8'h14, 32'd2, "R4 decrement");
      pulse();
      pulse();
      chk_rd(8'h14, 32'd0, "R4 reached zero");
      chk_rd(8'h04, 32'h0, "R6 no flag before expiry");
      pulse();
      chk_rd(8'h04, 32'h1, "R6 flag0 set");
      chk_irq(1'b1, "R6 irq high");
      chk_rd(8'h00, 32'h0000_0800, "R8 run bit cleared");
      pulse();
      chk_rd(8'h14, 32'd0, "R8 parked at zero");

      // R10 write-zero clear
      wr(8'h04, 32'hFFFF_FFFF);
      chk_rd(8'h04, 32'h1, "R10 ones keep flag");
      wr(8'h04, 32'hFFFF_FEFF);
      chk_rd(8'h04, 32'h1, "R10 other bit zero keeps flag0");
      wr(8'h04, 32'hFFFF_FFFE);
      chk_rd(8'h04, 32'h0, "R10 zero clears flag0");
      chk_irq(1'b0, "R6 irq low after clear");

      // R7 periodic on timer 1
      wr(8'h18, 32'd2);
      wr(8'h1C, 32'd2);
      wr(8'h00, 32'h0000_100C);
      pulse();
      pulse();
      chk_rd(8'h1C, 32'd0, "R7 counted down");
      pulse();
      chk_rd(8'h1C, 32'd2, "R7 reloaded");
      chk_rd(8'h04, 32'h100, "R6 flag1 set");
      chk_rd(8'h00, 32'h0000_100C, "R7 keeps running");
      pulse();
      chk_rd(8'h1C, 32'd1, "R7 continues after reload");

      // R9 stop holds value
      wr(8'h00, 32'h0000_1008);
      pulse();
      pulse();
      chk_rd(8'h1C, 32'd1, "R9 value held");
      wr(8'h04, 32'h0);
      chk_rd(8'h04, 32'h0, "R10 flag1 cleared");

      // R7 free-running wrap
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h1C, 32'h0);
      wr(8'h00, 32'h0000_100C);
      pulse();
      chk_rd(8'h1C, 32'hFFFF_FFFF, "R7 wrap to all ones");
      pulse();
      chk_rd(8'h1C, 32'hFFFF_FFFE, "R7 free-run decrement");
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h0);

      // R5 fabric prescaler, divide by 4
      wr(8'h14, 32'd100);
      wr(8'h00, 32'h0010_0001);
      repeat (20) @(posedge clk);
      chk_rd(8'h14, 32'd95, "R5 divide by 4");
      wr(8'h00, 32'h0);

      // R5 divide by 32
      wr(8'h14, 32'd10);
      wr(8'h00, 32'h0028_0001);
      repeat (64) @(posedge clk);
      chk_rd(8'h14, 32'd8, "R5 divide by 32");
      wr(8'h00, 32'h0);

      // R5 divide by 1
      wr(8'h14, 32'd50);
      wr(8'h00, 32'h0000_0001);
      repeat (9) @(posedge clk);
      chk_rd(8'h14, 32'd40, "R5 divide by 1");
      wr(8'h00, 32'h0);
      chk_irq(1'b0, "R6 irq stays low");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule